// File: doc/BRIEF.md
# Upstream Bus Request Controller

This block runs the request/grant handshake that a bridge uses to take the primary bus when it forwards traffic upstream. The queue logic gives it a count of upstream entries that are fully written, either posted writes or delayed requests. An entry that is still being written is not in this count. The block raises the active-low request while that count is nonzero. It holds the request off for a short fixed time after one of its own transactions is ended by a retry, a disconnect or a target abort.

The external arbiter answers with an active-low grant. When grant arrives while the request is up, the block issues a one-cycle start strobe to the initiator datapath. It only does this when no frame or ready activity is on the bus and no earlier transaction of its own is still running. When grant arrives while no request is up, the block drives its parking enable, so the address/data, command and parity lines are held at valid levels. If work turns up while the bus is parked at the bridge, the start is issued straight away, without a fresh request/grant round. The transaction that was launched stays open until the datapath reports completion or one of the termination pulses arrives.

Top module: `upstream_req_ctrl`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `req_n`=1, `park_oe`=0 and `start_xfer`=0.
- R2: With no holdoff active, `req_n` is 0 in the cycle after an edge at which `pend_count` is nonzero.
- R3: `req_n` is 1 in the cycle after an edge at which `pend_count` is zero, so entries that are only partly queued never raise a request.
- R4: An edge that samples any of `term_retry`, `term_disconnect` or `term_abort` high forces `req_n` to 1 for exactly the two following cycles. After that, R2 and R3 apply again.
- R5: `start_xfer` is a single-cycle pulse. It is high in the cycle after an edge at which all of these hold: `req_n` was 0, `gnt_n` was 0, `pend_count` was nonzero, no holdoff was active and no launched transaction was open.
- R6: No start is issued from an edge at which `frame_n` or `irdy_n` is 0 (bus not idle).
- R7: `park_oe` is 1 in the cycle after an edge at which all of these hold: `gnt_n` was 0, `req_n` was 1, no transaction was open and no start was being issued.
- R8: `park_oe` is 0 in the cycle after any edge at which `gnt_n` is 1.
- R9: When `park_oe` is 1 and `pend_count` becomes nonzero, with the bus idle and no holdoff, `start_xfer` pulses in the next cycle without waiting for `req_n` to go low first.
- R10: After a start, no further start is issued until `xfer_done` or a termination pulse has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_count | input | CNT_W | Number of fully queued upstream entries |
| gnt_n | input | 1 | Active-low grant from the primary arbiter |
| frame_n | input | 1 | Active-low frame seen on the primary bus |
| irdy_n | input | 1 | Active-low initiator ready seen on the primary bus |
| term_retry | input | 1 | Pulse: own transaction ended by target retry |
| term_disconnect | input | 1 | Pulse: own transaction ended by target disconnect |
| term_abort | input | 1 | Pulse: own transaction ended by target abort |
| xfer_done | input | 1 | Pulse: own transaction completed normally |
| req_n | output | 1 | Active-low bus request |
| start_xfer | output | 1 | One-cycle strobe to begin a transaction |
| park_oe | output | 1 | Enable for driving parked address/data, command and parity lines |

## Verification
Each of the three outputs is registered. Its value is therefore due exactly one clock after the edge that samples the inputs causing it. The two-cycle request holdoff covers the first and second cycles after the termination edge. The bench drives its inputs on the falling edge. A behavioural model advances on each rising edge, and the outputs are compared with the model on the following falling edge. Explicit checks for each requirement are placed at the falling edge one cycle after the stimulus.

// File: rtl/ureq_pkg.sv
package ureq_pkg;

    typedef struct packed {
        logic retry;
        logic disconnect;
        logic abort;
    } term_t;

    typedef enum logic {
        LN_IDLE   = 1'b0,
        LN_ACTIVE = 1'b1
    } launch_st_e;

    typedef struct packed {
        logic req_n;
        logic start;
        logic park_oe;
    } bus_ctl_t;

    function automatic logic term_seen(input term_t t);
        return t.retry | t.disconnect | t.abort;
    endfunction

    function automatic logic bus_idle(input logic frame_n, input logic irdy_n);
        return frame_n & irdy_n;
    endfunction

endpackage

// File: rtl/ureq_holdoff.sv
module ureq_holdoff #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic term_hit,
    output logic quiet
);
    localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HW-1:0] RELOAD = HW'(HOLD_CYCLES - 1);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (term_hit)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign quiet = (cnt_q == '0) && !term_hit;

endmodule

// File: rtl/ureq_launch.sv
module ureq_launch
    import ureq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pend_any,
    input  logic allow,
    input  logic req_on,
    input  logic gnt_n,
    input  logic parked,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic term_hit,
    input  logic done,
    output logic start_d,
    output logic start_q,
    output logic busy
);
    launch_st_e st_q;
    logic       via_grant;
    logic       via_park;

    assign via_grant = req_on && !gnt_n;
    assign via_park  = parked;
    assign start_d   = (st_q == LN_IDLE) && pend_any && allow &&
                       bus_idle(frame_n, irdy_n) && (via_grant || via_park);
    assign busy      = (st_q == LN_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LN_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= start_d;
            if (start_d)
                st_q <= LN_ACTIVE;
            else if (term_hit || done)
                st_q <= LN_IDLE;
        end
    end

    // R5: start is never longer than one cycle
    a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R6: a start only follows an idle-bus sample
    a_r6_idle_bus: assert property (@(posedge clk) disable iff (rst)
        (!frame_n || !irdy_n) |=> !start_q);

    // R10: open transaction blocks another launch
    a_r10_single_launch: assert property (@(posedge clk) disable iff (rst)
        (busy && !term_hit && !done) |=> !start_q);

endmodule

// File: rtl/ureq_park.sv
module ureq_park (
    input  logic clk,
    input  logic rst,
    input  logic gnt_n,
    input  logic req_on,
    input  logic busy,
    input  logic start_d,
    output logic park_oe
);
    logic park_d;

    assign park_d = !gnt_n && !req_on && !busy && !start_d;

    always_ff @(posedge clk) begin
        if (rst)
            park_oe <= 1'b0;
        else
            park_oe <= park_d;
    end

    // R8: grant removal stops parking after one clock
    a_r8_park_release: assert property (@(posedge clk) disable iff (rst)
        gnt_n |=> !park_oe);

endmodule

// File: rtl/upstream_req_ctrl.sv
module upstream_req_ctrl
    import ureq_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int HOLD_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pend_count,
    input  logic             gnt_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             term_retry,
    input  logic             term_disconnect,
    input  logic             term_abort,
    input  logic             xfer_done,
    output logic             req_n,
    output logic             start_xfer,
    output logic             park_oe
);
    term_t    term;
    bus_ctl_t ctl;
    logic     term_hit;
    logic     allow;
    logic     pend_any;
    logic     req_n_q;
    logic     start_d;
    logic     start_q;
    logic     busy;
    logic     park_q;

    assign term     = '{retry: term_retry, disconnect: term_disconnect, abort: term_abort};
    assign term_hit = term_seen(term);
    assign pend_any = |pend_count;

    ureq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .term_hit (term_hit),
        .quiet    (allow)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_n_q <= 1'b1;
        else
            req_n_q <= !(pend_any && allow);
    end

    ureq_launch u_launch (
        .clk      (clk),
        .rst      (rst),
        .pend_any (pend_any),
        .allow    (allow),
        .req_on   (!req_n_q),
        .gnt_n    (gnt_n),
        .parked   (park_q),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .term_hit (term_hit),
        .done     (xfer_done),
        .start_d  (start_d),
        .start_q  (start_q),
        .busy     (busy)
    );

    ureq_park u_park (
        .clk     (clk),
        .rst     (rst),
        .gnt_n   (gnt_n),
        .req_on  (!req_n_q),
        .busy    (busy),
        .start_d (start_d),
        .park_oe (park_q)
    );

    assign ctl        = '{req_n: req_n_q, start: start_q, park_oe: park_q};
    assign req_n      = ctl.req_n;
    assign start_xfer = ctl.start;
    assign park_oe    = ctl.park_oe;

    // R1: reset leaves the bus interface quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (req_n && !park_oe && !start_xfer));

    // R4: request is released for two cycles after a termination
    a_r4_holdoff: assert property (@(posedge clk) disable iff (rst)
        term_hit |=> req_n ##1 req_n);

    // R3: an empty queue never leaves a request up
    a_r3_no_empty_req: assert property (@(posedge clk) disable iff (rst)
        !pend_any |=> req_n);

endmodule

// File: tb/tb_upstream_req_ctrl.sv
module tb_upstream_req_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pend_count = '0;
    logic       gnt_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1;
    logic       term_retry = 1'b0, term_disconnect = 1'b0, term_abort = 1'b0;
    logic       xfer_done = 1'b0;
    logic       req_n, start_xfer, park_oe;

    int checks = 0;
    int failures = 0;
    string tag = "R1";
    bit started = 0;

    // behavioural reference state (1 = active)
    int m_req = 0, m_start = 0, m_park = 0, m_hold = 0, m_busy = 0;

    always #5 clk = ~clk;

    upstream_req_ctrl #(.CNT_W(4), .HOLD_CYCLES(2)) dut (
        .clk(clk), .rst(rst), .pend_count(pend_count), .gnt_n(gnt_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .term_retry(term_retry),
        .term_disconnect(term_disconnect), .term_abort(term_abort),
        .xfer_done(xfer_done), .req_n(req_n), .start_xfer(start_xfer),
        .park_oe(park_oe)
    );

    always @(posedge clk) begin
        int term, ok, go;
        started = 1;
        if (rst) begin
            m_req = 0; m_start = 0; m_park = 0; m_hold = 0; m_busy = 0;
        end else begin
            term = (term_retry || term_disconnect || term_abort) ? 1 : 0;
            ok   = (m_hold == 0 && term == 0) ? 1 : 0;
            go   = (m_busy == 0 && pend_count != 0 && ok == 1 && frame_n && irdy_n &&
                    ((m_req == 1 && !gnt_n) || m_park == 1)) ? 1 : 0;
            m_park  = (!gnt_n && m_req == 0 && m_busy == 0 && go == 0) ? 1 : 0;
            m_req   = (pend_count != 0 && ok == 1) ? 1 : 0;
            if (term == 1) m_hold = 1;
            else if (m_hold > 0) m_hold = m_hold - 1;
            if (go == 1) m_busy = 1;
            else if (term == 1 || xfer_done) m_busy = 0;
            m_start = go;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (req_n !== (m_req == 0) || start_xfer !== (m_start == 1) ||
                park_oe !== (m_park == 1)) begin
                failures++;
                $display("FAIL %s model: req_n/start/park got %b%b%b expected %b%b%b",
                         tag, req_n, start_xfer, park_oe,
                         m_req == 0, m_start == 1, m_park == 1);
            end
        end
    end

    task automatic chk(input string rq, input string nm, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got %b expected %b", rq, nm, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        tag = "R1";
        chk("R1", "req_n", req_n, 1'b1);
        chk("R1", "park_oe", park_oe, 1'b0);
        chk("R1", "start_xfer", start_xfer, 1'b0);
        rst = 1'b0;

        tag = "R3"; pend_count = 0; cyc(4);
        chk("R3", "req_n idle", req_n, 1'b1);

        tag = "R2"; pend_count = 2; cyc(1);
        chk("R2", "req_n", req_n, 1'b0);
        pend_count = 0; cyc(1);
        chk("R3", "req_n drop", req_n, 1'b1);
        pend_count = 1; cyc(2);

        tag = "R5"; gnt_n = 1'b0; cyc(1);
        chk("R5", "start_xfer", start_xfer, 1'b1);
        cyc(1);
        chk("R5", "start single", start_xfer, 1'b0);
        frame_n = 1'b0; gnt_n = 1'b1; cyc(3);

        tag = "R10"; frame_n = 1'b1; gnt_n = 1'b0; cyc(4);
        chk("R10", "no relaunch", start_xfer, 1'b0);
        xfer_done = 1'b1; cyc(1); xfer_done = 1'b0; cyc(1);
        chk("R10", "relaunch after done", start_xfer, 1'b1);

        tag = "R6"; frame_n = 1'b0; xfer_done = 1'b1; cyc(1); xfer_done = 1'b0; cyc(3);
        chk("R6", "frame busy", start_xfer, 1'b0);
        frame_n = 1'b1; irdy_n = 1'b0; cyc(3);
        chk("R6", "irdy busy", start_xfer, 1'b0);
        irdy_n = 1'b1; cyc(1);
        chk("R6", "idle start", start_xfer, 1'b1);

        tag = "R4"; gnt_n = 1'b1; pend_count = 2; cyc(2);
        term_retry = 1'b1; cyc(1); term_retry = 1'b0;
        chk("R4", "hold 1", req_n, 1'b1); cyc(1);
        chk("R4", "hold 2", req_n, 1'b1); cyc(1);
        chk("R4", "resume", req_n, 1'b0);
        term_disconnect = 1'b1; cyc(1); term_disconnect = 1'b0; cyc(3);
        term_abort = 1'b1; cyc(1); term_abort = 1'b0;
        chk("R4", "abort hold", req_n, 1'b1); cyc(3);

        tag = "R7"; pend_count = 0; gnt_n = 1'b0; cyc(3);
        chk("R7", "park_oe", park_oe, 1'b1);
        tag = "R8"; gnt_n = 1'b1; cyc(1);
        chk("R8", "park release", park_oe, 1'b0);

        tag = "R9"; gnt_n = 1'b0; cyc(3);
        chk("R9", "parked", park_oe, 1'b1);
        pend_count = 1; cyc(1);
        chk("R9", "parked start", start_xfer, 1'b1);
        xfer_done = 1'b1; pend_count = 0; cyc(1); xfer_done = 1'b0; cyc(2);

        tag = "random";
        for (int i = 0; i < 3000; i++) begin
            pend_count      = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(1, 5));
            gnt_n           = $urandom_range(0, 1) != 0;
            frame_n         = $urandom_range(0, 4) != 0;
            irdy_n          = $urandom_range(0, 4) != 0;
            term_retry      = $urandom_range(0, 19) == 0;
            term_disconnect = $urandom_range(0, 19) == 0;
            term_abort      = $urandom_range(0, 29) == 0;
            xfer_done       = (m_busy == 1) && ($urandom_range(0, 3) == 0);
            cyc(1);
        end
        finish_run();
    end
endmodule